// File: doc/BRIEF.md
# Scanline Table Transfer Engine

This block drives a small set of channels that each walk a table held in byte-wide memory on the A side and push data units to a peripheral port on the B side. The transfers happen once per scanline, during horizontal blanking. Each table entry is a line-count byte followed by data units. The count byte sets how many scanlines the entry covers and whether a unit goes out on every one of those lines or only on the first.

A frame-start strobe re-arms the engine. It clears every channel's pending and finished flags, and it drops all channels from service. After a short delay, the engine arms the channels whose enable bits are set at that moment. For each armed channel it cancels any general-purpose DMA running on that channel, points the channel at the start of its table, and reads the first count byte. The delay depends on a free-running 3-bit cycle counter and on a silicon-revision parameter.

Software sets each channel's transfer mode, base port and table start through a write port. It can read the current table address, the count byte, the start address and the flags back through a combinational read port.

Top module: `line_xfer_eng`

## Requirements
- R1: A frame_start pulse clears the pending flag and the finished flag of every channel, enabled or not. Flags read back with rd_sel=2 as bit1 = finished and bit0 = pending. Both read 0 after reset.
- R2: At arming time, each channel with its en_mask bit set reloads its current address (rd_sel=0) from its start address (cfg_sel=2), then reads one count byte. A non-zero byte leaves the current address at start+1, the count byte (rd_sel=1) equal to that byte, and pending set.
- R3: At arming time, dma_abort pulses for exactly one cycle on every channel that is both enabled and has dma_busy high. It stays low on all other channels.
- R4: A count byte of 00h sets the finished flag. That channel then makes no more reads or writes and its address stops advancing until the next frame_start.
- R5: The mode field (cfg_sel=0, bits 1:0) selects the unit size and the ports. Mode 0 writes one byte to the base port. Modes 1 and 3 write two bytes, to the base port and then the base port + 1. Mode 2 writes two bytes, both to the base port.
- R6: The current address grows by one for each table byte read. The 7-bit count in bits 6:0 of the count byte drops by one on each serviced hblank. When it reaches zero, the next count byte is read at once.
- R7: Let c be the number of clock edges since reset release, modulo 8, counted up to the edge that samples frame_start. The first memory request comes exactly D cycles after that edge. D = 20 − c when REV=1 and D = 12 + c when REV=2.
- R8: Count byte bit 7 set means a unit goes out on every line of the run. Bit 7 clear means a unit goes out on the first line only, and the channel stays quiet for the remaining lines.
- R9: On an hblank, channels are serviced in ascending channel number. Each pending, unfinished channel moves one unit.
- R10: mem_req stays high with mem_addr stable until mem_rdy is seen, and only one read is outstanding at a time.
- R11: A channel whose enable bit was clear at arming time makes no reads or writes for the rest of that frame, even if its enable bit is set later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start-of-frame strobe |
| hblank | input | 1 | Horizontal blanking strobe, honoured while idle |
| en_mask | input | NCH | Channel enable bits |
| dma_busy | input | NCH | General DMA active, per channel |
| dma_abort | output | NCH | One-cycle cancel toward general DMA |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | log2(NCH) | Channel written |
| cfg_sel | input | 2 | 0 mode, 1 base port, 2 table start |
| cfg_wdata | input | AW | Write data |
| rd_ch | input | log2(NCH) | Channel read |
| rd_sel | input | 2 | 0 current address, 1 count byte, 2 flags, 3 start |
| rd_data | output | AW | Read data |
| mem_req | output | 1 | Table read request |
| mem_addr | output | AW | Table read address |
| mem_rdy | input | 1 | Read data valid this cycle |
| mem_rdata | input | 8 | Table byte |
| bw_en | output | 1 | B-side write strobe |
| bw_port | output | 8 | B-side port |
| bw_data | output | 8 | B-side data |

## Verification
The bench sweeps the frame start over all eight counter phases and measures the exact request delay each time. A wrong offset formula, or a counter that does not free-run, shows up as an off-by-N count. It starts one channel in one frame and enables a second mid-frame. A design that arms late channels would consume the second channel's table from a stale address and emit stray writes. A frame with a finished channel disabled checks that its flags still clear. The mode and repeat checks would catch a run that keeps writing after its first line, a two-byte unit with the wrong port step, or service in the wrong order.

// File: rtl/line_xfer_eng.sv
module line_xfer_eng #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int REV = 2,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          hblank,
  input  logic [NCH-1:0] en_mask,
  input  logic [NCH-1:0] dma_busy,
  output logic [NCH-1:0] dma_abort,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_ch,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [CW-1:0] rd_ch,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rdy,
  input  logic [7:0]    mem_rdata,
  output logic          bw_en,
  output logic [7:0]    bw_port,
  output logic [7:0]    bw_data
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SVC, S_FETCH, S_STEP} st_t;

  logic [1:0]    mode_r  [NCH];
  logic [7:0]    port_r  [NCH];
  logic [AW-1:0] start_r [NCH];
  logic [AW-1:0] cur_r   [NCH];
  logic [7:0]    lc_r    [NCH];
  logic [NCH-1:0] xfer, done, act;

  st_t        st;
  logic [CW-1:0] ch;
  logic       lc_kind, bsel, init_ph;
  logic [4:0] wcnt;
  logic [2:0] fr_cnt;

  wire [NCH-1:0] pend  = act & ~done;
  wire [4:0]     delay = (REV == 1) ? 5'd20 - {2'b0, fr_cnt} : 5'd12 + {2'b0, fr_cnt};
  wire           two   = (mode_r[ch] != 2'd0);

  logic nx_ok, fp_ok, fe_ok;
  logic [CW-1:0] nx_ch, fp_ch, fe_ch;

  always_comb begin
    nx_ok = 1'b0; nx_ch = '0;
    fp_ok = 1'b0; fp_ch = '0;
    fe_ok = 1'b0; fe_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i] && i > int'(ch)) begin nx_ok = 1'b1; nx_ch = CW'(i); end
      if (pend[i])                 begin fp_ok = 1'b1; fp_ch = CW'(i); end
      if (en_mask[i])              begin fe_ok = 1'b1; fe_ch = CW'(i); end
    end
  end

  assign mem_req  = (st == S_FETCH);
  assign mem_addr = cur_r[ch];

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'd0: rd_data = cur_r[rd_ch];
      2'd1: rd_data[7:0] = lc_r[rd_ch];
      2'd2: rd_data[1:0] = {done[rd_ch], xfer[rd_ch]};
      default: rd_data = start_r[rd_ch];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        mode_r[i] <= '0; port_r[i] <= '0; start_r[i] <= '0;
        cur_r[i] <= '0; lc_r[i] <= '0;
      end
      xfer <= '0; done <= '0; act <= '0;
      st <= S_IDLE; ch <= '0; lc_kind <= 1'b0; bsel <= 1'b0; init_ph <= 1'b0;
      wcnt <= '0; fr_cnt <= '0; dma_abort <= '0;
      bw_en <= 1'b0; bw_port <= '0; bw_data <= '0;
    end else begin
      fr_cnt    <= fr_cnt + 3'd1;
      bw_en     <= 1'b0;
      dma_abort <= '0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: mode_r[cfg_ch]  <= cfg_wdata[1:0];
          2'd1: port_r[cfg_ch]  <= cfg_wdata[7:0];
          2'd2: start_r[cfg_ch] <= cfg_wdata;
          default: ;
        endcase
      end
      if (frame_start) begin
        xfer <= '0; done <= '0; act <= '0;
        st   <= S_WAIT;
        wcnt <= delay;
      end else begin
        case (st)
          S_IDLE: if (hblank && fp_ok) begin
            ch <= fp_ch; init_ph <= 1'b0; st <= S_SVC;
          end
          S_WAIT: if (wcnt == 5'd1) begin
            act       <= en_mask;
            dma_abort <= en_mask & dma_busy;
            for (int i = 0; i < NCH; i++)
              if (en_mask[i]) cur_r[i] <= start_r[i];
            if (fe_ok) begin
              ch <= fe_ch; init_ph <= 1'b1; lc_kind <= 1'b1; st <= S_FETCH;
            end else st <= S_IDLE;
          end else wcnt <= wcnt - 5'd1;
          S_SVC: if (xfer[ch]) begin
            lc_kind <= 1'b0; bsel <= 1'b0; st <= S_FETCH;
          end else st <= S_STEP;
          S_FETCH: if (mem_rdy) begin
            cur_r[ch] <= cur_r[ch] + 1'b1;
            if (lc_kind) begin
              if (mem_rdata == 8'h00) begin
                done[ch] <= 1'b1; xfer[ch] <= 1'b0;
              end else begin
                lc_r[ch] <= mem_rdata; xfer[ch] <= 1'b1;
              end
              if (nx_ok) begin
                ch <= nx_ch;
                st <= init_ph ? S_FETCH : S_SVC;
              end else st <= S_IDLE;
            end else begin
              bw_en   <= 1'b1;
              bw_port <= port_r[ch] + {7'd0, mode_r[ch][0] & bsel};
              bw_data <= mem_rdata;
              if (two && !bsel) bsel <= 1'b1;
              else st <= S_STEP;
            end
          end
          S_STEP: begin
            lc_r[ch][6:0] <= lc_r[ch][6:0] - 7'd1;
            xfer[ch]      <= lc_r[ch][7];
            if (lc_r[ch][6:0] == 7'd1) begin
              lc_kind <= 1'b1; st <= S_FETCH;
            end else if (nx_ok) begin
              ch <= nx_ch; st <= S_SVC;
            end else st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_flags_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (done == '0 && xfer == '0));

  assert_abort_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_abort != '0) |=> (dma_abort == '0));

  assert_finished_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !done[ch]);

  assert_write_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bw_en |-> $past(mem_req && mem_rdy));

  assert_no_early_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !mem_req);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy && !frame_start) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/line_xfer_eng_tb.sv
`timescale 1ns/1ps
module line_xfer_eng_tb;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic clk = 0, rst_n = 0;
  logic frame_start = 0, hblank = 0;
  logic [NCH-1:0] en_mask = '0, dma_busy = '0, dma_abort;
  logic cfg_we = 0;
  logic [1:0] cfg_ch = 0, cfg_sel = 0, rd_ch = 0, rd_sel = 0;
  logic [AW-1:0] cfg_wdata = '0, rd_data, mem_addr;
  logic mem_req, mem_rdy = 0, bw_en;
  logic [7:0] mem_rdata, bw_port, bw_data;

  line_xfer_eng u_dut (.*);

  always #4 clk = ~clk;

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  int lat = 0, wc = 0;
  always @(posedge clk) begin
    if (mem_req && !mem_rdy) begin
      if (wc >= lat) begin mem_rdy <= 1; wc <= 0; end
      else wc <= wc + 1;
    end else mem_rdy <= 0;
  end

  int bc = 0;
  always @(posedge clk) if (!rst_n) bc <= 0; else bc <= bc + 1;

  int nw = 0;
  logic [7:0] lp [64], ld [64];
  always @(posedge clk) if (bw_en && nw < 64) begin
    lp[nw] <= bw_port; ld[nw] <= bw_data; nw <= nw + 1;
  end

  int ab [NCH];
  initial for (int i = 0; i < NCH; i++) ab[i] = 0;
  always @(posedge clk) for (int i = 0; i < NCH; i++) if (dma_abort[i]) ab[i] = ab[i] + 1;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int c, input int s, input int v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(c); cfg_sel = 2'(s); cfg_wdata = AW'(v);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int c, input int s, output int v);
    rd_ch = 2'(c); rd_sel = 2'(s); #1; v = int'(rd_data);
  endtask

  task automatic hb();
    @(negedge clk); hblank = 1;
    @(negedge clk); hblank = 0;
    repeat (60) @(negedge clk);
  endtask

  task automatic frame(output int k, output int c);
    @(negedge clk);
    frame_start = 1; c = bc % 8;
    @(negedge clk); frame_start = 0;
    k = 1;
    while (!mem_req && k < 60) begin @(negedge clk); k++; end
    repeat (60) @(negedge clk);
  endtask

  task automatic chkw(input string tag, input int idx, input int p, input int d);
    chk({tag, " port"}, int'(lp[idx]), p);
    chk({tag, " data"}, int'(ld[idx]), d);
  endtask

  initial begin
    int v, k, c, w0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h10] = 8'h02; mem[8'h11] = 8'h77; mem[8'h12] = 8'h55; mem[8'h13] = 8'h00;
    mem[8'h20] = 8'h02; mem[8'h21] = 8'h77; mem[8'h22] = 8'h55; mem[8'h23] = 8'h00;
    mem[8'h40] = 8'h82; mem[8'h41] = 8'hA1; mem[8'h42] = 8'hA2; mem[8'h43] = 8'h00;
    mem[8'h60] = 8'h01; mem[8'h61] = 8'hB1; mem[8'h62] = 8'hB2; mem[8'h63] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, 2, v); chk("R1 reset flags", v, 0);
    chk("R10 reset no req", int'(mem_req), 0);
    chk("R5 reset no write", int'(bw_en), 0);

    cfg(0, 0, 2); cfg(0, 1, 8'h88); cfg(0, 2, 16'h0010);
    cfg(1, 0, 2); cfg(1, 1, 8'h88); cfg(1, 2, 16'h0020);
    cfg(2, 0, 0); cfg(2, 1, 8'h10); cfg(2, 2, 16'h0040);
    cfg(3, 0, 3); cfg(3, 1, 8'h20); cfg(3, 2, 16'h0060);

    // R7 delay sweep over every counter phase, R2 arming result
    en_mask = 4'b0001;
    for (int t = 0; t < 8; t++) begin
      lat = t % 3;
      @(negedge clk);
      while (bc % 8 != t) @(negedge clk);
      frame_start = 1; c = bc % 8;
      @(negedge clk); frame_start = 0;
      k = 1;
      while (!mem_req && k < 60) begin @(negedge clk); k++; end
      chk("R7 request delay", k - 1, 12 + c);
      repeat (40) @(negedge clk);
      rd(0, 0, v); chk("R2 addr after arm", v, 16'h0011);
      rd(0, 1, v); chk("R2 count byte", v, 8'h02);
      rd(0, 2, v); chk("R2 pending set", v, 1);
    end

    // first line: mode 2, both bytes to base port
    lat = 1;
    w0 = nw; hb();
    chk("R5 mode2 count", nw - w0, 2);
    chkw("R5 mode2 b0", w0, 8'h88, 8'h77);
    chkw("R5 mode2 b1", w0 + 1, 8'h88, 8'h55);
    rd(0, 0, v); chk("R6 addr advance", v, 16'h0013);
    rd(0, 1, v); chk("R6 count decrement", v, 8'h01);
    rd(0, 2, v); chk("R8 paused after first line", v, 0);

    // R11 enable mid-frame
    en_mask = 4'b0011;
    rd(1, 0, w0); k = w0;
    w0 = nw; hb();
    chk("R8 no write while paused", nw - w0, 0);
    rd(0, 2, v); chk("R4 finished flag", v, 2);
    rd(0, 0, v); chk("R4 terminator consumed", v, 16'h0014);
    rd(1, 0, v); chk("R11 late channel untouched", v, k);
    w0 = nw; hb();
    chk("R4 no writes after finish", nw - w0, 0);
    rd(0, 0, v); chk("R4 addr frozen", v, 16'h0014);

    // R1 flags clear on disabled channel, R3 abort on enabled+busy only
    en_mask = 4'b0010; dma_busy = 4'b0011;
    frame(k, c);
    dma_busy = '0;
    rd(0, 2, v); chk("R1 disabled flags cleared", v, 0);
    chk("R3 abort enabled busy", ab[1], 1);
    chk("R3 no abort disabled", ab[0], 0);
    rd(1, 0, v); chk("R2 ch1 addr", v, 16'h0021);

    // R9 ordering, modes 0/1/3, repeat
    cfg(1, 0, 1);
    en_mask = 4'b1111; lat = 2;
    frame(k, c);
    w0 = nw; hb();
    chk("R9 line1 writes", nw - w0, 7);
    chkw("R9 ch0 b0", w0, 8'h88, 8'h77);
    chkw("R9 ch0 b1", w0 + 1, 8'h88, 8'h55);
    chkw("R5 mode1 b0", w0 + 2, 8'h88, 8'h77);
    chkw("R5 mode1 b1", w0 + 3, 8'h89, 8'h55);
    chkw("R5 mode0", w0 + 4, 8'h10, 8'hA1);
    chkw("R5 mode3 b0", w0 + 5, 8'h20, 8'hB1);
    chkw("R5 mode3 b1", w0 + 6, 8'h21, 8'hB2);
    rd(3, 2, v); chk("R4 ch3 finished", v, 2);
    rd(2, 1, v); chk("R6 repeat count", v, 8'h81);
    w0 = nw; hb();
    chk("R8 repeat line2 count", nw - w0, 1);
    chkw("R8 repeat line2", w0, 8'h10, 8'hA2);
    rd(2, 2, v); chk("R4 ch2 finished", v, 2);
    w0 = nw; hb();
    chk("R4 all finished quiet", nw - w0, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule